// File: doc/BRIEF.md
# SPI Word Buffer and Interrupt Front End

This block sits between a simple host register bus and the shift engine of an SPI master. The host writes outgoing 32-bit words into a transmit queue and reads incoming words from a receive queue. Both queues use one shared data address. The shift engine takes transmit words through a valid/ready handshake. It delivers each received word as a single-cycle valid pulse.

Each queue is eight words deep. Each queue has a threshold and a flush control. Three sticky event flags sit in one interrupt status word: receive-complete, receive-overrun and transmit-complete. The host clears them by writing ones to that same address. A live receive-ready flag sits next to them in the same word. A single interrupt line combines the receive-complete and overrun events with their enables. A global enable gates the engine side of both queues. Register access works whether or not the enable is set.

Register word addresses on `busAddr`: 0x0 control, 0x1 queue control, 0x2 status, 0x3 interrupt enable, 0x4 interrupt status/clear, 0x5 data. A read returns its value on `busRdata` in the cycle after the strobe. The read value stays there until the next read.

Top module: `spi_fifo_irq`

## Requirements
- R1: Control bit 0 is the engine enable and resets to 0. While it is 0, `txValid` stays low and words presented on `rxValid` are discarded without any flag change. Bus writes to the data address still fill the transmit queue.
- R2: A bus write to address 0x5 appends `busWdata` to the transmit queue. The engine receives the words on `txData` in write order, one word per cycle with `txValid` and `txReady` both high. A write to a full queue (8 words) is dropped.
- R3: A bus read of address 0x5 removes the oldest received word and returns it on the next cycle. A read from an empty receive queue returns 0 and changes nothing.
- R4: Status (0x2) bit 0 is 1 exactly when the receive queue holds at least one word.
- R5: Queue control (0x1) holds the transmit threshold in bits 11:8 and the receive threshold in bits 3:0. A write with bit 12 set empties the transmit queue in that cycle, and a write with bit 4 set does the same for the receive queue. Both flush bits read back as 0.
- R6: Interrupt status bit 3 (receive-complete) is set when a received word brings the queue level exactly to the effective receive threshold. The effective threshold is 1 when the field is 0, 8 when the field is above 8, and the field value otherwise.
- R7: Interrupt status bit 9 reads 1 whenever the current receive level is at or above the effective receive threshold. This bit is not sticky.
- R8: Interrupt status bit 0 (overrun) is set when an enabled word arrives while the receive queue holds 8 words. That word is dropped and the stored words are unchanged.
- R9: Interrupt status bit 4 (transmit-complete) is set when the engine takes a word and the transmit level that remains is at or below the transmit threshold field.
- R10: Writing address 0x4 clears each of bits 4, 3 and 0 that is written as 1. If a bit is set in the same cycle as it is cleared, it stays set. Bit 9 is unaffected by the write.
- R11: `irq` equals (status bit 3 AND enable bit 3) OR (status bit 0 AND enable bit 0), with the enables at address 0x3. Bit 4 never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid one cycle after the strobe |
| irq | output | 1 | Combined interrupt request |
| txValid | output | 1 | A transmit word is offered to the engine |
| txReady | input | 1 | Engine takes the offered word |
| txData | output | 32 | Offered transmit word |
| rxValid | input | 1 | Engine delivers a received word |
| rxData | input | 32 | Received word |

## Verification
The embedded assertions check every cycle that:
- neither queue level exceeds its depth;
- a write into a full queue leaves the level unchanged;
- a flush empties a queue by the next cycle;
- a disabled engine cannot move the receive level;
- an overrun event always shows up as the sticky flag;
- a rise of receive-complete always follows an accepted word;
- a lone transmit-complete flag never drives the interrupt.

The bench scenarios are needed for the rest:
- word order through both queues;
- the zero-on-empty read;
- the threshold clamping;
- the live ready flag;
- set-over-clear priority at the shared status address;
- the flush read-back.

A seeded random mix of host and engine traffic is compared against a bench model.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;

  // register word addresses
  localparam logic [3:0] ADDR_CTRL  = 4'h0;
  localparam logic [3:0] ADDR_QCTL  = 4'h1;
  localparam logic [3:0] ADDR_STAT  = 4'h2;
  localparam logic [3:0] ADDR_IEN   = 4'h3;
  localparam logic [3:0] ADDR_ISTAT = 4'h4;
  localparam logic [3:0] ADDR_DATA  = 4'h5;

  // field positions
  localparam int EN_BIT       = 0;
  localparam int TX_FLUSH_BIT = 12;
  localparam int TX_THR_LSB   = 8;
  localparam int RX_FLUSH_BIT = 4;
  localparam int RX_THR_LSB   = 0;
  localparam int THR_W        = 4;
  localparam int NE_BIT       = 0;
  localparam int RDY_BIT      = 9;
  localparam int TXC_BIT      = 4;
  localparam int RXC_BIT      = 3;
  localparam int OVR_BIT      = 0;

  // control -> datapath
  typedef struct packed {
    logic engineEn;
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } dpStrobeT;

  // datapath -> control
  typedef struct packed {
    logic txPushed;
    logic txPopped;
    logic rxPushed;
    logic rxPopped;
    logic rxOverrun;
  } dpEventT;

endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             pushOk,
  output logic             popOk
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;

  assign full   = (count == LVL_W'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = push && !full && !flush;
  assign popOk  = pop && !empty && !flush;
  assign level  = count;
  assign headData = empty ? '0 : mem[rdPtr];

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= ptrNext(wrPtr);
      if (popOk)  rdPtr <= ptrNext(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= LVL_W'(DEPTH));

  // R2
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop && !flush) |=> $stable(count));

  // R5
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push && !flush) |=> (count == '0));

endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  logic [WIDTH-1:0] txWord,
  output logic             txValid,
  input  logic             txReady,
  output logic [WIDTH-1:0] txData,
  input  logic             rxValid,
  input  logic [WIDTH-1:0] rxData,
  output logic [WIDTH-1:0] rxHead,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             rxEmpty,
  output dpEventT          events
);
  logic txFull, txEmpty, rxFull;
  logic txPushOk, txPopOk, rxPushOk, rxPopOk;
  logic rxPushReq;

  assign txValid   = strobe.engineEn && !txEmpty;
  assign rxPushReq = strobe.engineEn && rxValid;

  spi_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LVL_W(LVL_W)) u_txq (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush),
    .push(strobe.txPush), .pushData(txWord),
    .pop(txValid && txReady), .headData(txData),
    .level(txLevel), .full(txFull), .empty(txEmpty),
    .pushOk(txPushOk), .popOk(txPopOk)
  );

  spi_word_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LVL_W(LVL_W)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush),
    .push(rxPushReq), .pushData(rxData),
    .pop(strobe.rxPop), .headData(rxHead),
    .level(rxLevel), .full(rxFull), .empty(rxEmpty),
    .pushOk(rxPushOk), .popOk(rxPopOk)
  );

  assign events.txPushed  = txPushOk;
  assign events.txPopped  = txPopOk;
  assign events.rxPushed  = rxPushOk;
  assign events.rxPopped  = rxPopOk;
  assign events.rxOverrun = rxPushReq && rxFull && !strobe.rxFlush;

  // R1
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.engineEn && rxValid && !strobe.rxPop && !strobe.rxFlush) |=> $stable(rxLevel));

  // R1
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.engineEn && !strobe.txPush && !strobe.txFlush) |=> $stable(txLevel));

endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int AW    = 4,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AW-1:0]    busAddr,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  output logic             irq,
  input  logic [WIDTH-1:0] rxHead,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             rxEmpty,
  input  dpEventT          events,
  output dpStrobeT         strobe
);
  logic             enReg, ieRx, ieOvr;
  logic [THR_W-1:0] txThr, rxThr;
  logic             stTx, stRx, stOvr;
  logic [WIDTH-1:0] rdQ, rdMux;
  logic             wrHit, rdHit;
  logic             clrTx, clrRx, clrOvr;
  logic             setTx, setRx, setOvr;
  logic             rdyLive;
  int               effRx, rxPost, txPost;

  assign wrHit = busSel && busWr;
  assign rdHit = busSel && !busWr;

  assign strobe.engineEn = enReg;
  assign strobe.txPush   = wrHit && (busAddr == AW'(ADDR_DATA));
  assign strobe.rxPop    = rdHit && (busAddr == AW'(ADDR_DATA));
  assign strobe.txFlush  = wrHit && (busAddr == AW'(ADDR_QCTL)) && busWdata[TX_FLUSH_BIT];
  assign strobe.rxFlush  = wrHit && (busAddr == AW'(ADDR_QCTL)) && busWdata[RX_FLUSH_BIT];

  always_comb begin
    if (rxThr == '0)              effRx = 1;
    else if (int'(rxThr) > DEPTH) effRx = DEPTH;
    else                          effRx = int'(rxThr);
    rxPost = int'(rxLevel) + int'(events.rxPushed) - int'(events.rxPopped);
    txPost = int'(txLevel) + int'(events.txPushed) - int'(events.txPopped);
  end

  assign rdyLive = int'(rxLevel) >= effRx;
  assign setRx   = events.rxPushed && (rxPost == effRx);
  assign setTx   = events.txPopped && (txPost <= int'(txThr));
  assign setOvr  = events.rxOverrun;

  assign clrTx  = wrHit && (busAddr == AW'(ADDR_ISTAT)) && busWdata[TXC_BIT];
  assign clrRx  = wrHit && (busAddr == AW'(ADDR_ISTAT)) && busWdata[RXC_BIT];
  assign clrOvr = wrHit && (busAddr == AW'(ADDR_ISTAT)) && busWdata[OVR_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= 1'b0;
      ieRx  <= 1'b0;
      ieOvr <= 1'b0;
      txThr <= '0;
      rxThr <= '0;
      stTx  <= 1'b0;
      stRx  <= 1'b0;
      stOvr <= 1'b0;
    end else begin
      if (wrHit && busAddr == AW'(ADDR_CTRL)) enReg <= busWdata[EN_BIT];
      if (wrHit && busAddr == AW'(ADDR_QCTL)) begin
        txThr <= busWdata[TX_THR_LSB +: THR_W];
        rxThr <= busWdata[RX_THR_LSB +: THR_W];
      end
      if (wrHit && busAddr == AW'(ADDR_IEN)) begin
        ieRx  <= busWdata[RXC_BIT];
        ieOvr <= busWdata[OVR_BIT];
      end
      stTx  <= (stTx  && !clrTx)  || setTx;
      stRx  <= (stRx  && !clrRx)  || setRx;
      stOvr <= (stOvr && !clrOvr) || setOvr;
    end
  end

  always_comb begin
    rdMux = '0;
    case (busAddr)
      AW'(ADDR_CTRL):  rdMux[EN_BIT] = enReg;
      AW'(ADDR_QCTL): begin
        rdMux[TX_THR_LSB +: THR_W] = txThr;
        rdMux[RX_THR_LSB +: THR_W] = rxThr;
      end
      AW'(ADDR_STAT):  rdMux[NE_BIT] = !rxEmpty;
      AW'(ADDR_IEN): begin
        rdMux[RXC_BIT] = ieRx;
        rdMux[OVR_BIT] = ieOvr;
      end
      AW'(ADDR_ISTAT): begin
        rdMux[RDY_BIT] = rdyLive;
        rdMux[TXC_BIT] = stTx;
        rdMux[RXC_BIT] = stRx;
        rdMux[OVR_BIT] = stOvr;
      end
      AW'(ADDR_DATA):  rdMux = rxHead;
      default:         rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)      rdQ <= '0;
    else if (rdHit) rdQ <= rdMux;
  end

  assign busRdata = rdQ;
  assign irq = (stRx && ieRx) || (stOvr && ieOvr);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    events.rxOverrun |=> stOvr);

  // R6
  rxc_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stRx) |-> $past(events.rxPushed));

  // R11
  txc_no_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stTx && !stRx && !stOvr) |-> !irq);

  // R10
  w1c_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrOvr && !events.rxOverrun) |=> !stOvr);

endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic [AW-1:0]    busAddr,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  output logic             irq,
  output logic             txValid,
  input  logic             txReady,
  output logic [WIDTH-1:0] txData,
  input  logic             rxValid,
  input  logic [WIDTH-1:0] rxData
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  dpStrobeT         strobe;
  dpEventT          events;
  logic [WIDTH-1:0] rxHead;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic             rxEmpty;

  spi_fifo_ctl #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW), .LVL_W(LVL_W)) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel), .rxEmpty(rxEmpty),
    .events(events), .strobe(strobe)
  );

  spi_fifo_dp #(.DEPTH(DEPTH), .WIDTH(WIDTH), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWord(busWdata),
    .txValid(txValid), .txReady(txReady), .txData(txData),
    .rxValid(rxValid), .rxData(rxData), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxEmpty(rxEmpty), .events(events)
  );

endmodule

// File: tb/spi_fifo_irq_tb.sv
module spi_fifo_irq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, txValid, txReady = 1'b0, rxValid = 1'b0;
  logic [31:0] txData, rxData = '0;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  logic [31:0] mTx[$], mRx[$];
  bit mEn, mIeRx, mIeOvr, mStTx, mStRx, mStOvr;
  int mTxThr, mRxThr;

  always #4 clk = ~clk;

  spi_fifo_irq u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .txValid(txValid),
    .txReady(txReady), .txData(txData), .rxValid(rxValid), .rxData(rxData)
  );

  function automatic int effThr(input int t);
    if (t == 0) return 1;
    if (t > 8) return 8;
    return t;
  endfunction

  function automatic logic [31:0] expIstat();
    logic [31:0] v = '0;
    v[9] = (mRx.size() >= effThr(mRxThr));
    v[4] = mStTx;
    v[3] = mStRx;
    v[0] = mStOvr;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
    case (a)
      4'h0: mEn = d[0];
      4'h1: begin
        if (d[12]) mTx.delete();
        if (d[4])  mRx.delete();
        mTxThr = int'(d[11:8]);
        mRxThr = int'(d[3:0]);
      end
      4'h3: begin mIeRx = d[3]; mIeOvr = d[0]; end
      4'h4: begin
        if (d[4]) mStTx = 0;
        if (d[3]) mStRx = 0;
        if (d[0]) mStOvr = 0;
      end
      4'h5: if (mTx.size() < 8) mTx.push_back(d);
      default: ;
    endcase
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk);
    busSel = 0;
    d = busRdata;
  endtask

  task automatic readData(input string tag);
    logic [31:0] d, e;
    e = (mRx.size() > 0) ? mRx.pop_front() : 32'h0;
    busRead(4'h5, d);
    chk(tag, d, e);
  endtask

  task automatic engineTake(input string tag);
    bit ev;
    logic v;
    logic [31:0] d;
    txReady = 1;
    v = txValid; d = txData;
    @(negedge clk);
    txReady = 0;
    ev = mEn && (mTx.size() > 0);
    chk({tag, " txValid"}, {31'h0, v}, {31'h0, ev});
    if (ev) begin
      chk({tag, " txData"}, d, mTx.pop_front());
      if (mTx.size() <= mTxThr) mStTx = 1;
    end
  endtask

  task automatic rxArrive(input logic [31:0] d);
    rxValid = 1; rxData = d;
    @(negedge clk);
    rxValid = 0;
    if (mEn) begin
      if (mRx.size() == 8) mStOvr = 1;
      else begin
        mRx.push_back(d);
        if (mRx.size() == effThr(mRxThr)) mStRx = 1;
      end
    end
  endtask

  task automatic checkIstat(input string tag);
    logic [31:0] d;
    busRead(4'h4, d);
    chk(tag, d, expIstat());
  endtask

  task automatic checkStat(input string tag);
    logic [31:0] d;
    busRead(4'h2, d);
    chk(tag, d, {31'h0, mRx.size() > 0});
  endtask

  task automatic checkIrq(input string tag);
    chk(tag, {31'h0, irq}, {31'h0, (mStRx && mIeRx) || (mStOvr && mIeOvr)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // reset state (R1, R4, R5, R10)
    busRead(4'h0, d); chk("R1 reset ctrl", d, 32'h0);
    busRead(4'h1, d); chk("R5 reset qctl", d, 32'h0);
    checkStat("R4 reset status");
    checkIstat("R10 reset istat");
    chk("R1 reset txValid", {31'h0, txValid}, 32'h0);
    checkIrq("R11 reset irq");

    // disabled engine (R1)
    busWrite(4'h5, 32'hA1); busWrite(4'h5, 32'hA2);
    engineTake("R1 disabled take");
    rxArrive(32'hBEEF);
    checkStat("R1 disabled rx dropped");
    checkIstat("R1 disabled no flags");

    // enable, tx order and full drop (R2)
    busWrite(4'h0, 32'h1);
    busWrite(4'h1, 32'h0000_0F00);
    for (int i = 0; i < 7; i++) busWrite(4'h5, 32'h100 + i);
    busWrite(4'h5, 32'hDEAD_0009);
    for (int i = 0; i < 9; i++) engineTake("R2 tx order");
    engineTake("R2 tx empty");

    // empty read (R3)
    readData("R3 empty read zero");
    checkStat("R3 empty read no effect");

    // threshold 0 acts as 1 (R6, R7, R11, R10)
    busWrite(4'h3, 32'h9);
    busWrite(4'h1, 32'h0);
    rxArrive(32'hC0DE_0001);
    checkIstat("R6 thr0 rx complete");
    checkIrq("R11 irq on rx complete");
    busWrite(4'h4, 32'h8);
    checkIstat("R10 clear keeps ready bit R7");
    checkIrq("R11 irq after clear");
    readData("R3 read one");

    // threshold above depth clamps; overrun (R6, R8)
    busWrite(4'h1, 32'h0000_000C);
    for (int i = 0; i < 8; i++) begin
      rxArrive(32'h2000 + i);
      if (i == 6) checkIstat("R6 R7 below clamp");
    end
    checkIstat("R6 clamp to depth");
    rxArrive(32'hFFFF_FFFF);
    checkIstat("R8 overrun flag");
    checkIrq("R11 irq on overrun");
    for (int i = 0; i < 8; i++) readData("R8 R3 rx order");
    checkStat("R4 drained");
    busWrite(4'h4, 32'h19);

    // flush (R5)
    for (int i = 0; i < 3; i++) begin busWrite(4'h5, 32'h300 + i); rxArrive(32'h400 + i); end
    busWrite(4'h1, 32'h0000_1315);
    busRead(4'h1, d); chk("R5 flush bits read zero", d, 32'h0000_0305);
    checkStat("R5 rx flushed");
    engineTake("R5 tx flushed");

    // set wins over clear (R10)
    busWrite(4'h1, 32'h1);
    rxArrive(32'h55);
    readData("R10 prep read");
    busSel = 1; busWr = 1; busAddr = 4'h4; busWdata = 32'h8;
    rxValid = 1; rxData = 32'h66;
    @(negedge clk);
    busSel = 0; busWr = 0; rxValid = 0;
    mRx.push_back(32'h66); mStRx = 1;
    checkIstat("R10 set wins over clear");
    readData("R10 word kept");
    busWrite(4'h4, 32'h19);

    // tx complete never drives irq (R9, R11)
    busWrite(4'h1, 32'h0000_0101);
    busWrite(4'h5, 32'h77); busWrite(4'h5, 32'h78);
    engineTake("R9 take one");
    checkIstat("R9 tx complete at threshold");
    checkIrq("R11 tx complete no irq");
    engineTake("R9 take two");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      case (op)
        0, 1: busWrite(4'h5, $urandom);
        2:    engineTake("R2 random take");
        3, 4: rxArrive($urandom);
        5:    readData("R3 random read");
        6:    checkIstat("R6 R7 R8 R9 random istat");
        7:    busWrite(4'h4, $urandom & 32'h19);
        8:    checkStat("R4 random status");
        default: begin
          logic [31:0] w = {19'h0, ($urandom_range(0, 15) == 0), $urandom_range(0, 15),
                            3'h0, ($urandom_range(0, 15) == 0), $urandom_range(0, 15)};
          if ($urandom_range(0, 3) == 0) busWrite(4'h1, w);
          else if ($urandom_range(0, 7) == 0) busWrite(4'h0, {31'h0, $urandom_range(0, 3) != 0});
          else busWrite(4'h3, $urandom & 32'h9);
        end
      endcase
      checkIrq("R11 random irq");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule